// File: doc/BRIEF.md
# Two-Wire Clock-Generator Control Register Slave

This block is the serial control port of a clock generator. It is a slave on a two-wire SMBus-style bus, sampled on the system clock. The bus master changes the generator's configuration with a block write: an address byte, then a command byte whose value is discarded, then a byte count, then data bytes. The data bytes fill three control registers in order. A read at the companion address returns the count first and then the three registers. The block never drives SDA high. It only pulls the line low through an output-enable.

Some register bits hold settings with fixed reset values. These drive the generator through the configuration outputs. Other bits are read-only windows onto live pins: the CPU stop pin, the three frequency selects and the current-multiplier select. One read-back bit shows the effective PCI stop. That value combines a stored enable bit with the external active-low stop pin, and the block also drives it out directly.

Top module: `smb_clkctl_slave`

## Requirements
- R1: The slave acknowledges only the 8-bit address byte 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and it changes no register.
- R2: After a write address, the command byte and the count byte are both acknowledged. The command value has no effect on which register the first data byte reaches.
- R3: The data bytes after the count are stored in register 0, then register 1, then register 2. Each one is acknowledged.
- R4: Register contents persist across stop conditions and later transactions until reset.
- R5: After reset, the writable bits of register 0 (bits 7, 6 and 5) are 0 and its internal PCI stop bit (bit 3) is 1. Register 1 bits 6 to 3 are 0 and bits 2 to 0 are 1. Register 2 is 0x00.
- R6: Register 0 bit 4 reads the CPU stop pin. Register 0 bits 2, 1 and 0 read selects S2, S1 and S0. Register 1 bit 7 reads the multiplier pin. Writes to these positions are ignored.
- R7: Register 0 bit 3 reads as the AND of the stored bit and the active-low PCI stop pin. The same value drives `pci_stop_eff_n_o`.
- R8: Data bytes after the third one are acknowledged and discarded.
- R9: A read returns the count value 3, then registers 0, 1 and 2, then 0xFF for any further byte. The read ends when the master answers a byte with NACK.
- R10: SDA is only pulled low, and its drive changes only while SCL is low. A start (SDA falling with SCL high) restarts address reception. A stop (SDA rising with SCL high) returns the slave to idle with SDA released.
- R11: Outputs are driven from the registers: `spread_en_o`, `pd_tristate_o` and `alt48_sel_o` come from register 0 bits 7..5. `stop_tristate_o` comes from register 1 bit 6. `free_run_o[2:0]` comes from register 1 bits 5..3, and `out_en_o[2:0]` from bits 2..0. `aux_cfg_o` is register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cpu_stop_n_i | input | 1 | CPU stop pin, active low |
| pci_stop_n_i | input | 1 | PCI stop pin, active low |
| sel_i | input | 3 | Frequency select pins S2..S0 |
| mult_i | input | 1 | Current-multiplier select pin |
| spread_en_o | output | 1 | Spread enable |
| pd_tristate_o | output | 1 | Power-down tri-state select |
| alt48_sel_o | output | 1 | Alternate output frequency select |
| pci_stop_eff_n_o | output | 1 | Effective PCI stop, active low |
| stop_tristate_o | output | 1 | Tri-state CPU outputs while stopped |
| free_run_o | output | 3 | Per-CPU-output free-run enables |
| out_en_o | output | 3 | Per-CPU-output enables |
| aux_cfg_o | output | 8 | Register 2 contents |

## Verification
One register write and one pin change can land in the same system-clock cycle. This happens when a data byte for register 0 is stored while the PCI stop pin is also moving. The effective stop output must then show the new stored bit ANDed with the new pin level. The bench lowers the PCI stop pin in the middle of a write that sets the stored bit. It then checks `pci_stop_eff_n_o` and the read-back bit 3 against the AND of the written bit and the pin. Reads that run past the third register, and writes that run past it, check that the saturating pointer serves 0xFF and discards the extra bytes.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TACK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } eng_phase_t;

  localparam logic [6:0] SLAVE_ADDR7 = 7'h69;
endpackage

// File: rtl/smbc_sync.sv
module smbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbc_engine.sv
module smbc_engine
  import smbc_pkg::*;
#(
  parameter int NREG = 3,
  localparam int IW = $clog2(NREG + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_byte,
  output logic [IW-1:0] ptr_o,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [IW-1:0] WR_LAST = IW'(NREG);
  localparam logic [IW-1:0] RD_LAST = IW'(NREG + 1);

  eng_state_t state_q, state_d;
  eng_phase_t phase_q, phase_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    sh_q, sh_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          rd_q, rd_d;
  logic          drv_q, drv_d;
  logic          nack_q, nack_d;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    ptr_d    = ptr_q;
    rd_d     = rd_q;
    drv_d    = drv_q;
    nack_d   = nack_q;
    wr_en    = 1'b0;
    if (start_det) begin
      state_d  = ST_RX;
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      ptr_d    = '0;
      drv_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      drv_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d     = {sh_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            if (phase_q == PH_ADDR) begin
              if (sh_q[7:1] == SLAVE_ADDR7) begin
                rd_d    = sh_q[0];
                drv_d   = 1'b1;
                state_d = ST_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              drv_d   = 1'b1;
              state_d = ST_ACK;
              if (phase_q == PH_DATA && ptr_q < WR_LAST) begin
                wr_en = 1'b1;
                ptr_d = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (rd_q) begin
              state_d = ST_TX;
              sh_d    = rd_byte;
              drv_d   = ~rd_byte[7];
              if (ptr_q < RD_LAST) ptr_d = ptr_q + 1'b1;
            end else begin
              state_d = ST_RX;
              drv_d   = 1'b0;
              if (phase_q != PH_DATA) phase_d = eng_phase_t'(phase_q + 2'd1);
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              drv_d   = 1'b0;
              state_d = ST_TACK;
            end else begin
              bitcnt_d = bitcnt_q + 4'd1;
              sh_d     = {sh_q[6:0], 1'b1};
              drv_d    = ~sh_q[6];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) nack_d = sda_s;
          else if (scl_fall) begin
            if (nack_q) state_d = ST_IDLE;
            else begin
              state_d  = ST_TX;
              bitcnt_d = '0;
              sh_d     = rd_byte;
              drv_d    = ~rd_byte[7];
              if (ptr_q < RD_LAST) ptr_d = ptr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      rd_q     <= 1'b0;
      drv_q    <= 1'b0;
      nack_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      ptr_q    <= ptr_d;
      rd_q     <= rd_d;
      drv_q    <= drv_d;
      nack_q   <= nack_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = drv_q;

  // R10: the data drive moves only in the SCL low phase
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);
  // R10: a stop releases the line and idles
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state_q == ST_IDLE && !sda_oe));
  // R10: a start restarts address reception
  assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_RX && phase_q == PH_ADDR && bitcnt_q == 4'd0));
  // R8: stores never run past the last register
  assert_write_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr_q < WR_LAST && phase_q == PH_DATA && !rd_q));
endmodule

// File: rtl/smbc_regfile.sv
module smbc_regfile #(
  parameter int NREG = 3,
  localparam int IW = $clog2(NREG + 2)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [7:0]                wr_data,
  input  logic [IW-1:0]             rd_idx,
  output logic [7:0]                rd_byte,
  input  logic                      cpu_stop_n_i,
  input  logic                      pci_stop_n_i,
  input  logic [2:0]                sel_i,
  input  logic                      mult_i,
  output logic [2:0]                ctl0_o,
  output logic                      pci_eff_n_o,
  output logic [6:0]                ctl1_o,
  output logic [NREG-3:0][7:0]      aux_o
);
  function automatic logic [7:0] wmask(int i);
    if (i == 0) return 8'hE8;
    else if (i == 1) return 8'h7F;
    else return 8'hFF;
  endfunction

  function automatic logic [7:0] rdefault(int i);
    if (i == 0) return 8'h08;
    else if (i == 1) return 8'h07;
    else return 8'h00;
  endfunction

  logic [NREG-1:0][7:0] regs_q;
  logic [NREG-1:0][7:0] view;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] WM = wmask(g);
    localparam logic [7:0] RD = rdefault(g);
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= RD;
      else if (hit) regs_q[g] <= (wr_data & WM) | (regs_q[g] & ~WM);
    end
    if (g == 0) begin : g_v0
      assign view[g] = {regs_q[g][7:5], cpu_stop_n_i,
                        regs_q[g][3] & pci_stop_n_i, sel_i};
    end else if (g == 1) begin : g_v1
      assign view[g] = {mult_i, regs_q[g][6:0]};
    end else begin : g_vn
      assign view[g] = regs_q[g];
      assign aux_o[g-2] = regs_q[g];
    end
  end

  always_comb begin
    if (rd_idx == '0) rd_byte = 8'(NREG);
    else if (rd_idx <= IW'(NREG)) rd_byte = view[rd_idx - 1'b1];
    else rd_byte = 8'hFF;
  end

  assign ctl0_o      = regs_q[0][7:5];
  assign pci_eff_n_o = regs_q[0][3] & pci_stop_n_i;
  assign ctl1_o      = regs_q[1][6:0];

  // R4: without a store the registers keep their contents
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/smb_clkctl_slave.sv
module smb_clkctl_slave #(
  parameter int NREG = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       cpu_stop_n_i,
  input  logic       pci_stop_n_i,
  input  logic [2:0] sel_i,
  input  logic       mult_i,
  output logic       spread_en_o,
  output logic       pd_tristate_o,
  output logic       alt48_sel_o,
  output logic       pci_stop_eff_n_o,
  output logic       stop_tristate_o,
  output logic [2:0] free_run_o,
  output logic [2:0] out_en_o,
  output logic [7:0] aux_cfg_o
);
  localparam int IW = $clog2(NREG + 2);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IW-1:0] ptr;
  logic          wr_en;
  logic [7:0]    wr_data, rd_byte;
  logic [2:0]    ctl0;
  logic [6:0]    ctl1;
  logic [NREG-3:0][7:0] aux;

  smbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbc_engine #(.NREG(NREG)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_byte(rd_byte), .ptr_o(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  smbc_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_idx(ptr),
    .wr_data(wr_data), .rd_idx(ptr), .rd_byte(rd_byte),
    .cpu_stop_n_i(cpu_stop_n_i), .pci_stop_n_i(pci_stop_n_i),
    .sel_i(sel_i), .mult_i(mult_i), .ctl0_o(ctl0),
    .pci_eff_n_o(pci_stop_eff_n_o), .ctl1_o(ctl1), .aux_o(aux)
  );

  assign spread_en_o     = ctl0[2];
  assign pd_tristate_o   = ctl0[1];
  assign alt48_sel_o     = ctl0[0];
  assign stop_tristate_o = ctl1[6];
  assign free_run_o      = ctl1[5:3];
  assign out_en_o        = ctl1[2:0];
  assign aux_cfg_o       = aux[0];
endmodule

// File: tb/smb_clkctl_slave_test.sv
module smb_clkctl_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic cpu_n = 1'b1, pci_n = 1'b1, mult = 1'b0;
  logic [2:0] sel = 3'b000;
  logic sda_oe;
  logic spread, pdts, alt48, pcieff, stopts;
  logic [2:0] frun, oen;
  logic [7:0] aux;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign sda_line = sda_oe ? 1'b0 : sda_m;
  always #2 clk = ~clk;

  smb_clkctl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cpu_stop_n_i(cpu_n), .pci_stop_n_i(pci_n), .sel_i(sel), .mult_i(mult),
    .spread_en_o(spread), .pd_tristate_o(pdts), .alt48_sel_o(alt48),
    .pci_stop_eff_n_o(pcieff), .stop_tristate_o(stopts), .free_run_o(frun),
    .out_en_o(oen), .aux_cfg_o(aux)
  );

  // {d0, d1, d2, pins = {2'b0, mult, cpu_n, pci_n, sel[2:0]}}
  localparam logic [31:0] VEC [6] = '{
    32'hE0_FF_5A_3F, 32'hFF_80_A5_00, 32'h08_7F_01_15,
    32'h17_2A_FF_2A, 32'hA8_55_3C_1C, 32'h00_00_00_27
  };

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic xfer(input logic b, output logic r);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q); r = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xfer(v[i], r);
    xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin xfer(1'b1, r); v[i] = r; end
    xfer(last, r);
  endtask

  task automatic wr_txn(input logic [7:0] addr, input logic [7:0] cmd,
                        input logic [7:0] d [5], input int n, output logic all_ack,
                        output logic addr_ack);
    logic a;
    bstart();
    put_byte(addr, addr_ack);
    all_ack = addr_ack;
    if (addr_ack) begin
      put_byte(cmd, a); all_ack &= a;
      put_byte(8'(n), a); all_ack &= a;
      for (int i = 0; i < n; i++) begin put_byte(d[i], a); all_ack &= a; end
    end
    bstop();
  endtask

  task automatic rd_txn(input int n, output logic [7:0] q [6], output logic ack);
    bstart();
    put_byte(8'hD3, ack);
    for (int i = 0; i < n; i++) get_byte(i == n - 1, q[i]);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [5];
    logic [7:0] q [6];
    logic ack, aack;
    logic [7:0] e0, e1;
    wq(5); rst_n = 1'b1; wq(10);

    // R5/R11 reset state on the outputs
    chk("R5 outputs", {spread, pdts, alt48, stopts, frun, 1'b0},
        {3'b000, 1'b0, 3'b000, 1'b0});
    chk("R5 out_en", {5'b0, oen}, 8'h07);
    chk("R5 aux", aux, 8'h00);
    chk("R7 reset eff", {7'b0, pcieff}, 8'h01);
    rd_txn(4, q, ack);
    chk("R1 read ack", {7'b0, ack}, 8'h01);
    chk("R9 count", q[0], 8'h03);
    chk("R5 reg0", q[1], {3'b000, cpu_n, pci_n, sel});
    chk("R5 reg1", q[2], {mult, 7'h07});
    chk("R5 reg2", q[3], 8'h00);

    // Table walk: R2 R3 R6 R7 R11 under varied data and pins
    for (int v = 0; v < 6; v++) begin
      {mult, cpu_n, pci_n, sel} = VEC[v][5:0];
      d[0] = VEC[v][31:24]; d[1] = VEC[v][23:16]; d[2] = VEC[v][15:8];
      d[3] = 8'h00; d[4] = 8'h00;
      wr_txn(8'hD2, 8'(v * 37 + 11), d, 3, ack, aack);
      chk("R2 R3 acks", {7'b0, ack}, 8'h01);
      rd_txn(4, q, ack);
      e0 = {d[0][7:5], cpu_n, d[0][3] & pci_n, sel};
      e1 = {mult, d[1][6:0]};
      chk("R9 count", q[0], 8'h03);
      chk("R3 R6 R7 reg0", q[1], e0);
      chk("R3 R6 reg1", q[2], e1);
      chk("R3 reg2", q[3], d[2]);
      chk("R11 outputs", {spread, pdts, alt48, pcieff, stopts, 3'b0},
          {d[0][7:5], d[0][3] & pci_n, d[1][6], 3'b0});
      chk("R11 cpu ctl", {2'b0, frun, oen}, {2'b0, d[1][5:3], d[1][2:0]});
      chk("R11 aux", aux, d[2]);
    end

    // R1: foreign addresses are not acknowledged and change nothing
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    wr_txn(8'hA4, 8'h00, d, 3, ack, aack);
    chk("R1 nack A4", {7'b0, aack}, 8'h00);
    wr_txn(8'hD0, 8'h00, d, 3, ack, aack);
    chk("R1 nack D0", {7'b0, aack}, 8'h00);
    chk("R1 R4 aux kept", aux, 8'h00);

    // R8: extra data bytes acked and dropped; R6 read-only positions ignored
    {mult, cpu_n, pci_n, sel} = 6'b0_0_1_000;
    d = '{8'hFF, 8'hFF, 8'h5C, 8'hC3, 8'h96};
    wr_txn(8'hD2, 8'hFF, d, 5, ack, aack);
    chk("R8 extra acked", {7'b0, ack}, 8'h01);
    rd_txn(6, q, ack);
    chk("R6 ro ignored reg0", q[1], 8'hE8);
    chk("R6 ro ignored reg1", q[2], 8'h7F);
    chk("R8 reg2 kept", q[3], 8'h5C);
    chk("R9 past end a", q[4], 8'hFF);
    chk("R9 past end b", q[5], 8'hFF);

    // R4: contents persist across further transactions
    rd_txn(4, q, ack);
    chk("R4 persist", q[3], 8'h5C);
    chk("R4 aux", aux, 8'h5C);

    // R7: pin drops while the stored bit is being written
    pci_n = 1'b1;
    d = '{8'h08, 8'h07, 8'h5C, 8'h00, 8'h00};
    fork
      wr_txn(8'hD2, 8'h00, d, 1, ack, aack);
      begin wq(Q * 4 * 9 * 3 + Q * 4 * 7); pci_n = 1'b0; end
    join
    chk("R7 eff low", {7'b0, pcieff}, 8'h00);
    rd_txn(2, q, ack);
    chk("R7 readback", q[1] & 8'h08, 8'h00);
    pci_n = 1'b1; wq(4);
    chk("R7 eff high", {7'b0, pcieff}, 8'h01);

    // R10: repeated start aborts a write and restarts addressing
    bstart();
    put_byte(8'hD2, aack);
    put_byte(8'h00, ack);
    wr_txn(8'hD2, 8'h00, '{8'h20, 8'h07, 8'h77, 8'h00, 8'h00}, 3, ack, aack);
    chk("R10 restart", aux, 8'h77);
    chk("R10 released", {7'b0, sda_oe}, 8'h00);

    // Reset restores defaults
    rst_n = 1'b0; wq(3); rst_n = 1'b1; wq(5);
    chk("R5 after reset aux", aux, 8'h00);
    chk("R5 after reset ctl", {spread, pdts, alt48, stopts, frun, 1'b0}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule